// File: doc/BRIEF.md
# Primary-Side Data Parity Error Reporter

This block keeps the primary-side parity error status of a two-port bus bridge and drives its active-low system error line. A data-phase strobe marks each cycle in which the bus logic presents a classified data phase. The phase is described by the kind of transfer, its direction across the bridge, and the bus on which a parity error was seen. Further inputs carry the two parity-error-response enables, the system-error enable, a parity error report from a target on the primary bus, and a flag that says the bad data arrived already poisoned from the other side of the bridge.

Three sticky status bits record what happened: a detected-parity-error flag, a data-parity-detected flag and a signaled-system-error flag. Software clears them by writing ones through a small clear port. Whether a bit is set or the system error line pulses depends on the kind of transfer, on the direction, on the bus that saw the error and on whether the error was forwarded. There is no single rule that covers every error.

Top module: `perr_report_primary`

## Requirements
- R1: With the strobe high, an upstream read (`xfer_kind` 2'b00, `dir_up`=1) that has a parity error on the primary bus (`par_err`=1, `err_on_sec`=0) sets `det_par_err`, whatever the two parity-error-response enables are.
- R2: With the strobe high, a posted write (2'b01) or delayed write (2'b10) going downstream (`dir_up`=0) that has a parity error on the primary bus sets `det_par_err`, whatever the enables are.
- R3: No other combination sets `det_par_err`. This covers reads going downstream, any error seen on the secondary bus, writes going upstream, and the reserved kind 2'b11.
- R4: A target-reported error (`tgt_perr`=1) on an upstream posted or delayed write sets `dpar_det` only when `pri_per_en` is 1. `tgt_perr` has no effect on reads, on downstream phases or on the reserved kind.
- R5: A target-reported error on an upstream write sets `sig_sys_err` and pulses `serr_n` only when `serr_en`, `sec_per_en` and `pri_per_en` are all 1 and `fwd_err` is 0.
- R6: A phase with `fwd_err`=1 never pulls `serr_n` low and never sets `sig_sys_err`.
- R7: `serr_n` is registered. For each qualifying phase it goes low for exactly one cycle, starting at the clock edge that samples the phase. It is high at all other times.
- R8: A cycle with `clr_wr`=1 clears each status bit whose `clr_data` bit is 1: bit 0 `det_par_err`, bit 1 `dpar_det`, bit 2 `sig_sys_err`. The other bits keep their values.
- R9: If a set event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R10: While `dp_valid` is 0, no error input changes any status bit or `serr_n`.
- R11: While reset is asserted and after it is released, all status bits are 0 and `serr_n` is 1. Reset is asynchronous and active-low, and its release is synchronized inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_valid | input | 1 | Data-phase strobe; the other phase inputs are sampled only when this is high |
| xfer_kind | input | 2 | 00 read, 01 posted write, 10 delayed write, 11 reserved |
| dir_up | input | 1 | 1 = upstream (secondary to primary), 0 = downstream |
| err_on_sec | input | 1 | 1 = error seen on the secondary bus, 0 = on the primary bus |
| par_err | input | 1 | A data parity error was detected in this phase |
| tgt_perr | input | 1 | A target on the primary bus reported a data parity error |
| fwd_err | input | 1 | The error was forwarded across the bridge from the initiating bus |
| pri_per_en | input | 1 | Parity-error-response enable of the primary interface |
| sec_per_en | input | 1 | Parity-error-response enable of the secondary interface |
| serr_en | input | 1 | System-error enable |
| clr_wr | input | 1 | Write strobe for the write-one-to-clear port |
| clr_data | input | 3 | Clear mask: bit 0 detected, bit 1 data parity, bit 2 signaled system error |
| det_par_err | output | 1 | Sticky primary detected-parity-error status |
| dpar_det | output | 1 | Sticky data-parity-detected status |
| sig_sys_err | output | 1 | Sticky signaled-system-error status |
| serr_n | output | 1 | Active-low system error pulse |

## Verification
Some properties hold on every cycle, and assertions check them continuously. A status bit that is set stays set until it is cleared, and a set wins over a clear in the same cycle. An idle cycle leaves all state unchanged, a forwarded error never lowers the system error line, an error on the secondary bus never sets the detected bit, and every low cycle of `serr_n` follows a strobed phase and comes with the signaled flag set. Other behaviour has to be shown by directed scenarios in the bench. These cover the exact set of kind, direction and bus combinations that set the detected bit, the need for all three enables together before the system error fires, the one-cycle shape of the pulse, and the per-bit effect of the clear mask.

// File: rtl/perr_pkg.sv
package perr_pkg;

  typedef enum logic [1:0] {
    XK_READ    = 2'b00,
    XK_POSTED  = 2'b01,
    XK_DELAYED = 2'b10,
    XK_RSVD    = 2'b11
  } xfer_kind_e;

  localparam int unsigned ST_W    = 3;
  localparam int unsigned ST_DET  = 0;
  localparam int unsigned ST_DPAR = 1;
  localparam int unsigned ST_SIG  = 2;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/perr_rst_sync.sv
module perr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/perr_classify.sv
module perr_classify
  import perr_pkg::*;
(
  input  logic       dp_valid,
  input  xfer_kind_e kind,
  input  logic       dir_up,
  input  logic       err_on_sec,
  input  logic       par_err,
  input  logic       tgt_perr,
  input  logic       fwd_err,
  input  logic       pri_per_en,
  input  logic       sec_per_en,
  input  logic       serr_en,
  output logic       set_det,
  output logic       set_dpar,
  output logic       serr_evt
);

  logic is_write;
  logic det_case;
  logic up_write_tgt;

  always_comb begin
    is_write = (kind == XK_POSTED) || (kind == XK_DELAYED);

    // Primary-bus errors only: upstream reads, downstream writes.
    det_case = !err_on_sec &&
               (((kind == XK_READ) && dir_up) || (is_write && !dir_up));

    up_write_tgt = dp_valid && tgt_perr && is_write && dir_up;

    set_det  = dp_valid && par_err && det_case;
    set_dpar = up_write_tgt && pri_per_en;
    serr_evt = up_write_tgt && pri_per_en && sec_per_en && serr_en && !fwd_err;
  end

endmodule

// File: rtl/perr_sticky.sv
module perr_sticky #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic en;
    logic d;
    logic bit_q;

    always_comb begin
      en = set[i] || clr[i];
      d  = set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bit_q <= 1'b0;
      else if (en) bit_q <= d;
    end

    assign q[i] = bit_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> bit_q);

    // R8
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !bit_q);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_q && !clr[i]) |=> bit_q);
  end

endmodule

// File: rtl/perr_serr_pulse.sv
module perr_serr_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic serr_n
);

  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign serr_n = !pulse_q;

endmodule

// File: rtl/perr_report_primary.sv
module perr_report_primary
  import perr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_valid,
  input  logic [1:0] xfer_kind,
  input  logic       dir_up,
  input  logic       err_on_sec,
  input  logic       par_err,
  input  logic       tgt_perr,
  input  logic       fwd_err,
  input  logic       pri_per_en,
  input  logic       sec_per_en,
  input  logic       serr_en,
  input  logic       clr_wr,
  input  logic [2:0] clr_data,
  output logic       det_par_err,
  output logic       dpar_det,
  output logic       sig_sys_err,
  output logic       serr_n
);

  logic            rst_sync_n;
  logic            set_det;
  logic            set_dpar;
  logic            serr_evt;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] clr_vec;
  logic [ST_W-1:0] st_q;

  perr_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  perr_classify i_classify (
    .dp_valid   (dp_valid),
    .kind       (xfer_kind_e'(xfer_kind)),
    .dir_up     (dir_up),
    .err_on_sec (err_on_sec),
    .par_err    (par_err),
    .tgt_perr   (tgt_perr),
    .fwd_err    (fwd_err),
    .pri_per_en (pri_per_en),
    .sec_per_en (sec_per_en),
    .serr_en    (serr_en),
    .set_det    (set_det),
    .set_dpar   (set_dpar),
    .serr_evt   (serr_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_DET]  = set_det;
    set_vec[ST_DPAR] = set_dpar;
    set_vec[ST_SIG]  = serr_evt;
    clr_vec          = clr_wr ? clr_data[ST_W-1:0] : '0;
  end

  perr_sticky #(.W(ST_W)) i_sticky (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (set_vec),
    .clr   (clr_vec),
    .q     (st_q)
  );

  perr_serr_pulse i_serr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt    (serr_evt),
    .serr_n (serr_n)
  );

  assign det_par_err = st_q[ST_DET];
  assign dpar_det    = st_q[ST_DPAR];
  assign sig_sys_err = st_q[ST_SIG];

  // R6
  fwd_no_serr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_valid && fwd_err) |=> serr_n);

  // R5
  pulse_flagged_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !serr_n |-> sig_sys_err);

  // R7
  pulse_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !serr_n |-> $past(dp_valid));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!dp_valid && !clr_wr) |=> ($stable(st_q) && serr_n));

  // R3
  sec_bus_no_det_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_valid && err_on_sec && !clr_wr && !det_par_err) |=> !det_par_err);

  // R4
  no_enable_no_dpar_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dp_valid && !pri_per_en && !dpar_det) |=> !dpar_det);

endmodule

// File: tb/test_perr_report_primary.sv
module test_perr_report_primary;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dp_valid;
  logic [1:0] xfer_kind;
  logic       dir_up, err_on_sec, par_err, tgt_perr, fwd_err;
  logic       pri_per_en, sec_per_en, serr_en;
  logic       clr_wr;
  logic [2:0] clr_data;
  logic       det_par_err, dpar_det, sig_sys_err, serr_n;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  perr_report_primary i_perr_report_primary (
    .clk, .rst_n, .dp_valid, .xfer_kind, .dir_up, .err_on_sec, .par_err,
    .tgt_perr, .fwd_err, .pri_per_en, .sec_per_en, .serr_en, .clr_wr,
    .clr_data, .det_par_err, .dpar_det, .sig_sys_err, .serr_n
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dp_valid = 0; xfer_kind = 2'b00; dir_up = 0; err_on_sec = 0;
    par_err = 0; tgt_perr = 0; fwd_err = 0; clr_wr = 0; clr_data = 3'b000;
  endtask

  // Drive one strobed phase at a negedge; outputs are sampled at the next negedge.
  task automatic phase(input logic [1:0] k, input logic up, input logic sec,
                       input logic pe, input logic tp, input logic fw);
    dp_valid = 1; xfer_kind = k; dir_up = up; err_on_sec = sec;
    par_err = pe; tgt_perr = tp; fwd_err = fw;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_bits(input logic [2:0] mask);
    clr_wr = 1; clr_data = mask;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_en(input logic p, input logic s, input logic e);
    pri_per_en = p; sec_per_en = s; serr_en = e;
  endtask

  task automatic t_reset();
    chk("R11", "det after reset", det_par_err, 0);
    chk("R11", "dpar after reset", dpar_det, 0);
    chk("R11", "sig after reset", sig_sys_err, 0);
    chk("R11", "serr_n after reset", serr_n, 1);
  endtask

  task automatic t_det_set();
    set_en(0, 0, 0);
    phase(2'b00, 1, 0, 1, 0, 0);
    chk("R1", "det upstream read primary, enables off", det_par_err, 1);
    clear_bits(3'b111);
    set_en(1, 1, 1);
    phase(2'b00, 1, 0, 1, 0, 0);
    chk("R1", "det upstream read primary, enables on", det_par_err, 1);
    clear_bits(3'b111);
    set_en(0, 0, 0);
    phase(2'b01, 0, 0, 1, 0, 0);
    chk("R2", "det downstream posted primary", det_par_err, 1);
    clear_bits(3'b111);
    phase(2'b10, 0, 0, 1, 0, 0);
    chk("R2", "det downstream delayed primary", det_par_err, 1);
    clear_bits(3'b111);
  endtask

  task automatic t_det_matrix();
    set_en(1, 1, 0);
    for (int k = 0; k < 4; k++) begin
      for (int u = 0; u < 2; u++) begin
        for (int s = 0; s < 2; s++) begin
          logic exp;
          exp = (s == 0) && (((k == 0) && (u == 1)) ||
                             ((k == 1 || k == 2) && (u == 0)));
          phase(k[1:0], u[0], s[0], 1, 0, 0);
          chk(exp ? "R2" : "R3",
              $sformatf("det kind=%0d up=%0d sec=%0d", k, u, s), det_par_err, exp);
          clear_bits(3'b111);
        end
      end
    end
  endtask

  task automatic t_dpar();
    set_en(0, 1, 1);
    phase(2'b01, 1, 0, 0, 1, 0);
    chk("R4", "dpar with primary enable off", dpar_det, 0);
    set_en(1, 0, 0);
    phase(2'b01, 0, 0, 0, 1, 0);
    chk("R4", "dpar on downstream write", dpar_det, 0);
    phase(2'b00, 1, 0, 0, 1, 0);
    chk("R4", "dpar on upstream read", dpar_det, 0);
    phase(2'b11, 1, 0, 0, 1, 0);
    chk("R4", "dpar on reserved kind", dpar_det, 0);
    phase(2'b10, 1, 0, 0, 1, 0);
    chk("R4", "dpar on upstream delayed write", dpar_det, 1);
    chk("R4", "no serr without serr_en", serr_n, 1);
    clear_bits(3'b111);
  endtask

  task automatic t_serr();
    set_en(1, 1, 1);
    phase(2'b01, 1, 0, 0, 1, 0);
    chk("R5", "serr_n low after qualifying phase", serr_n, 0);
    chk("R5", "sig set", sig_sys_err, 1);
    @(negedge clk);
    chk("R7", "serr_n back high after one cycle", serr_n, 1);
    chk("R7", "sig stays set", sig_sys_err, 1);
    clear_bits(3'b111);
    for (int m = 0; m < 7; m++) begin
      set_en(m[0], m[1], m[2]);
      phase(2'b10, 1, 0, 0, 1, 0);
      chk("R5", $sformatf("serr_n with enables %0b", m[2:0]), serr_n, 1);
      chk("R5", $sformatf("sig with enables %0b", m[2:0]), sig_sys_err, 0);
      clear_bits(3'b111);
    end
  endtask

  task automatic t_back_to_back();
    set_en(1, 1, 1);
    dp_valid = 1; xfer_kind = 2'b01; dir_up = 1; tgt_perr = 1;
    @(negedge clk);
    chk("R7", "first pulse", serr_n, 0);
    @(negedge clk);
    idle_inputs();
    chk("R7", "second pulse", serr_n, 0);
    @(negedge clk);
    chk("R7", "high after two events", serr_n, 1);
    clear_bits(3'b111);
  endtask

  task automatic t_fwd();
    set_en(1, 1, 1);
    phase(2'b01, 1, 0, 0, 1, 1);
    chk("R6", "forwarded keeps serr_n high", serr_n, 1);
    chk("R6", "forwarded leaves sig clear", sig_sys_err, 0);
    chk("R4", "forwarded still sets dpar", dpar_det, 1);
    @(negedge clk);
    chk("R6", "serr_n still high", serr_n, 1);
    clear_bits(3'b111);
  endtask

  task automatic t_clear();
    set_en(1, 1, 1);
    phase(2'b00, 1, 0, 1, 0, 0);
    phase(2'b01, 1, 0, 0, 1, 0);
    chk("R8", "all set before clear", {sig_sys_err, dpar_det, det_par_err}, 3'b111);
    clear_bits(3'b010);
    chk("R8", "mask 010 clears dpar only", {sig_sys_err, dpar_det, det_par_err}, 3'b101);
    clear_bits(3'b001);
    chk("R8", "mask 001 clears det only", {sig_sys_err, dpar_det, det_par_err}, 3'b100);
    clear_bits(3'b100);
    chk("R8", "mask 100 clears sig", {sig_sys_err, dpar_det, det_par_err}, 3'b000);
  endtask

  task automatic t_race();
    set_en(1, 1, 1);
    dp_valid = 1; xfer_kind = 2'b01; dir_up = 1; tgt_perr = 1;
    clr_wr = 1; clr_data = 3'b111;
    @(negedge clk);
    idle_inputs();
    chk("R9", "dpar set wins over clear", dpar_det, 1);
    chk("R9", "sig set wins over clear", sig_sys_err, 1);
    chk("R8", "det cleared alongside", det_par_err, 0);
    clear_bits(3'b111);
  endtask

  task automatic t_idle();
    set_en(1, 1, 1);
    dp_valid = 0; xfer_kind = 2'b01; dir_up = 1; err_on_sec = 0;
    par_err = 1; tgt_perr = 1;
    repeat (3) @(negedge clk);
    chk("R10", "idle status", {sig_sys_err, dpar_det, det_par_err}, 3'b000);
    chk("R10", "idle serr_n", serr_n, 1);
    xfer_kind = 2'b00;
    @(negedge clk);
    chk("R10", "idle read status", det_par_err, 0);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    set_en(0, 0, 0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_det_set();
    t_det_matrix();
    t_dpar();
    t_serr();
    t_back_to_back();
    t_fwd();
    t_clear();
    t_race();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule